// File: doc/BRIEF.md
# Shadowed SRAM Store/Recall Controller

This block holds a small working SRAM in which every word has a nonvolatile shadow copy. A transfer engine moves the whole array in either direction. STORE copies working to shadow. RECALL copies shadow to working. A host reaches the working array through a port with active-low chip select, write strobe and read strobe, and with per-byte lane enables in the 16-bit build. The port is sampled on the clock. It has no valid/ready flow control: `ready` is the only gate, and an access presented while `ready` is low is dropped rather than held back.

Three events can start a STORE: a software pulse, an external agent pulling the shared busy line low, or a power-fail level. A power-fail STORE is skipped when the array has not been written since the last transfer, or when automatic saving is disabled. Two events can start a RECALL: a software pulse and a power-up pulse. The engine copies one word per clock. During a STORE that hardware started, the block drives the busy line low. After every STORE it drives the line high for a fixed number of cycles and then releases it to the pull-up. Completed STOREs are counted against an endurance limit. Once the limit is reached, no further STORE starts.

Top module: `nvshadow_ctrl`

## Requirements
- R1: When `ready`=1, `cs_n`=0 and `we_n`=0 on a clock edge, the word at `addr` takes `wdata` in each lane whose enable is low. `lb_n` gates bits 7:0 and `hb_n` gates bits 15:8. Lanes whose enable is high keep their old bytes.
- R2: When `ready`=1, `cs_n`=0 and `we_n`=1 on an edge, `rdata` after that edge holds the addressed word with disabled lanes read as zero. `rdata_oe` bit 0 (low lane) and bit 1 (high lane) are 1 only for enabled lanes, and only when `oe_n` was 0 at that edge. In every other case `rdata_oe` is 0.
- R3: A transfer holds `ready` low for exactly DEPTH cycles of copying. A STORE adds HOLD_CYC further cycles. Host writes and reads presented while `ready` is low change nothing.
- R4: A `sw_store` pulse copies every working word into the shadow array. During the copy `busy_oe` stays 0.
- R5: A `sw_recall` pulse copies every shadow word into the working array.
- R6: A `pwr_up` pulse starts a RECALL.
- R7: A high `pwr_fail` starts a STORE only when `auto_dis`=0 and at least one host write has been accepted since the last transfer began. Otherwise it is ignored.
- R8: When the block is not driving the busy line and `busy_in` is low, a STORE starts. During any STORE started by hardware (busy line or power fail), `busy_oe`=1 and `busy_out`=0.
- R9: After every STORE, `busy_oe`=1 and `busy_out`=1 for HOLD_CYC cycles, and then `busy_oe` returns to 0.
- R10: A trigger that arrives while a transfer or hold is running is dropped. `ready` stays high after that transfer ends.
- R11: `store_cnt` increments by one for each STORE, up to ENDUR_LIMIT. When it reaches the limit, `worn`=1 and STORE triggers are ignored.
- R12: When several triggers arrive in the same cycle, the order is: `pwr_up` recall, then power-fail store, then busy-line store, then `sw_store`, then `sw_recall`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Read drive enable, active low |
| hb_n | input | 1 | High lane enable, active low (16-bit build) |
| lb_n | input | 1 | Low lane enable, active low (16-bit build) |
| addr | input | ADDR_W | Word address |
| wdata | input | DW | Write data |
| rdata | output | DW | Registered read data |
| rdata_oe | output | NB | Per-lane drive enable for read data |
| sw_store | input | 1 | Software STORE pulse |
| sw_recall | input | 1 | Software RECALL pulse |
| pwr_up | input | 1 | Power-up pulse, starts RECALL |
| pwr_fail | input | 1 | Power-fail level |
| auto_dis | input | 1 | Suppresses the power-fail STORE |
| busy_in | input | 1 | Sensed level of the shared busy line |
| busy_out | output | 1 | Value driven onto the busy line |
| busy_oe | output | 1 | Busy line drive enable |
| ready | output | 1 | High when host access is accepted |
| store_cnt | output | CW | Completed STORE count |
| worn | output | 1 | Endurance limit reached |

## Verification
The bench starts a software STORE and, halfway through the copy, presents a host write and both software commands. A design that leaked the write would return corrupted data on the later read, and one that queued a command would drop `ready` again after the transfer. Power fail is checked with a clean array and with automatic saving disabled: a design that ignored the dirty flag or `auto_dis` would take `ready` low and bump the count. Simultaneous triggers test the priority order through the busy drive, which is low only for a hardware STORE and is followed by a high hold only for a STORE. The bench also runs STOREs up to the endurance limit, where a counter that wrapped or kept accepting would start a further copy.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_COPY = 2'd1,
    ST_HOLD = 2'd2
  } xfer_st_e;
endpackage

// File: rtl/nvs_ram.sv
module nvs_ram #(
  parameter int AW = 6,
  parameter int NB = 2
) (
  input  logic            clk,
  input  logic            we,
  input  logic [NB-1:0]   wmask,
  input  logic [AW-1:0]   waddr,
  input  logic [8*NB-1:0] wdata,
  input  logic [AW-1:0]   raddr,
  output logic [8*NB-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [8*NB-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int b = 0; b < NB; b++) begin
      if (we && wmask[b]) mem[waddr][8*b +: 8] <= wdata[8*b +: 8];
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/nvs_wear_ctr.sv
module nvs_wear_ctr #(
  parameter int LIMIT = 12,
  parameter int CW    = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  output logic [CW-1:0] cnt,
  output logic          worn
);
  localparam logic [CW-1:0] CAP = CW'(LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt <= '0;
    else if (inc && (cnt < CAP)) cnt <= cnt + 1'b1;
  end

  assign worn = (cnt == CAP);
endmodule

// File: rtl/nvs_xfer_fsm.sv
module nvs_xfer_fsm
  import nvs_pkg::*;
#(
  parameter int AW       = 6,
  parameter int HOLD_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_pu,
  input  logic          req_pf,
  input  logic          req_pin,
  input  logic          req_sw_st,
  input  logic          req_sw_rc,
  input  logic          store_ok,
  output logic          copying,
  output logic          dir_store,
  output logic [AW-1:0] idx,
  output logic          start,
  output logic          store_done,
  output logic          busy_out,
  output logic          busy_oe,
  output logic          ready
);
  localparam int HW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;

  xfer_st_e      st;
  logic          hw_src;
  logic [HW-1:0] hcnt;
  logic          nxt_store, nxt_hw;
  logic          last;

  always_comb begin
    start     = 1'b0;
    nxt_store = 1'b0;
    nxt_hw    = 1'b0;
    if (st == ST_IDLE) begin
      if (req_pu) begin
        start = 1'b1;
      end else if (store_ok && (req_pf || req_pin)) begin
        start = 1'b1; nxt_store = 1'b1; nxt_hw = 1'b1;
      end else if (store_ok && req_sw_st) begin
        start = 1'b1; nxt_store = 1'b1;
      end else if (req_sw_rc) begin
        start = 1'b1;
      end
    end
  end

  assign last = &idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      idx       <= '0;
      dir_store <= 1'b0;
      hw_src    <= 1'b0;
      hcnt      <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          st        <= ST_COPY;
          idx       <= '0;
          dir_store <= nxt_store;
          hw_src    <= nxt_hw;
        end
        ST_COPY: begin
          idx <= idx + 1'b1;
          if (last) begin
            if (dir_store) begin
              st   <= ST_HOLD;
              hcnt <= HW'(HOLD_CYC - 1);
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        ST_HOLD: begin
          if (hcnt == '0) st <= ST_IDLE;
          else            hcnt <= hcnt - 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign copying    = (st == ST_COPY);
  assign store_done = copying && last && dir_store;
  assign ready      = (st == ST_IDLE);
  assign busy_oe    = (st == ST_HOLD) || (copying && dir_store && hw_src);
  assign busy_out   = (st == ST_HOLD);
endmodule

// File: rtl/nvshadow_ctrl.sv
module nvshadow_ctrl #(
  parameter int ADDR_W      = 6,
  parameter int WIDE        = 1,
  parameter int HOLD_CYC    = 4,
  parameter int ENDUR_LIMIT = 12,
  localparam int NB = (WIDE != 0) ? 2 : 1,
  localparam int DW = 8 * NB,
  localparam int CW = $clog2(ENDUR_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              hb_n,
  input  logic              lb_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic [NB-1:0]     rdata_oe,
  input  logic              sw_store,
  input  logic              sw_recall,
  input  logic              pwr_up,
  input  logic              pwr_fail,
  input  logic              auto_dis,
  input  logic              busy_in,
  output logic              busy_out,
  output logic              busy_oe,
  output logic              ready,
  output logic [CW-1:0]     store_cnt,
  output logic              worn
);
  logic [NB-1:0]     lane_en;
  logic [DW-1:0]     lane_mask;
  logic              host_rd, host_wr;
  logic              copying, dir_store, start, store_done, dirty;
  logic [ADDR_W-1:0] idx;
  logic [DW-1:0]     w_rd, s_rd;

  generate
    if (WIDE != 0) begin : g_wide
      assign lane_en = {~hb_n, ~lb_n};
    end else begin : g_narrow
      assign lane_en = 1'b1;
    end
    for (genvar b = 0; b < NB; b++) begin : g_mask
      assign lane_mask[8*b +: 8] = {8{lane_en[b]}};
    end
  endgenerate

  assign host_rd = ready && !cs_n &&  we_n;
  assign host_wr = ready && !cs_n && !we_n;

  nvs_xfer_fsm #(.AW(ADDR_W), .HOLD_CYC(HOLD_CYC)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_pu    (pwr_up),
    .req_pf    (pwr_fail && !auto_dis && dirty),
    .req_pin   (!busy_in && !busy_oe),
    .req_sw_st (sw_store),
    .req_sw_rc (sw_recall),
    .store_ok  (!worn),
    .copying   (copying),
    .dir_store (dir_store),
    .idx       (idx),
    .start     (start),
    .store_done(store_done),
    .busy_out  (busy_out),
    .busy_oe   (busy_oe),
    .ready     (ready)
  );

  nvs_ram #(.AW(ADDR_W), .NB(NB)) u_work (
    .clk  (clk),
    .we   (host_wr || (copying && !dir_store)),
    .wmask(copying ? {NB{1'b1}} : lane_en),
    .waddr(copying ? idx : addr),
    .wdata(copying ? s_rd : wdata),
    .raddr(copying ? idx : addr),
    .rdata(w_rd)
  );

  nvs_ram #(.AW(ADDR_W), .NB(NB)) u_shadow (
    .clk  (clk),
    .we   (copying && dir_store),
    .wmask({NB{1'b1}}),
    .waddr(idx),
    .wdata(w_rd),
    .raddr(idx),
    .rdata(s_rd)
  );

  nvs_wear_ctr #(.LIMIT(ENDUR_LIMIT), .CW(CW)) u_wear (
    .clk  (clk),
    .rst_n(rst_n),
    .inc  (store_done),
    .cnt  (store_cnt),
    .worn (worn)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       dirty <= 1'b0;
    else if (start)   dirty <= 1'b0;
    else if (host_wr) dirty <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata    <= '0;
      rdata_oe <= '0;
    end else if (host_rd) begin
      rdata    <= w_rd & lane_mask;
      rdata_oe <= lane_en & {NB{!oe_n}};
    end else begin
      rdata_oe <= '0;
    end
  end
endmodule

// File: rtl/nvshadow_ctrl_chk.sv
module nvshadow_ctrl_chk #(
  parameter int ADDR_W      = 6,
  parameter int HOLD_CYC    = 4,
  parameter int ENDUR_LIMIT = 12,
  parameter int NB          = 2,
  parameter int CW          = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          oe_n,
  input logic          ready,
  input logic [NB-1:0] rdata_oe,
  input logic          busy_oe,
  input logic          busy_out,
  input logic [CW-1:0] store_cnt
);
  localparam int MAXRUN = (1 << ADDR_W) + HOLD_CYC;

  logic [CW-1:0] cnt_q;
  int unsigned   run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run   <= 0;
    end else begin
      cnt_q <= store_cnt;
      run   <= ready ? 0 : run + 1;
    end
  end

  p_lane_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(oe_n) |-> (rdata_oe == '0));

  p_quiet_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ready) |-> (rdata_oe == '0));

  p_span_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run <= MAXRUN);

  p_pull_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_oe && !busy_out) |-> !ready);

  p_release_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_oe) |-> $past(busy_out));

  p_cnt_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (store_cnt == cnt_q) || (store_cnt == cnt_q + CW'(1)));

  p_cnt_cap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    int'(store_cnt) <= ENDUR_LIMIT);
endmodule

bind nvshadow_ctrl nvshadow_ctrl_chk #(
  .ADDR_W(ADDR_W), .HOLD_CYC(HOLD_CYC), .ENDUR_LIMIT(ENDUR_LIMIT),
  .NB(NB), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .ready(ready),
  .rdata_oe(rdata_oe), .busy_oe(busy_oe), .busy_out(busy_out),
  .store_cnt(store_cnt)
);

// File: tb/nvshadow_ctrl_bench.sv
`timescale 1ns/1ps
module nvshadow_ctrl_bench;
  localparam int AW = 6, DEPTH = 64, HOLD = 4, LIM = 12, CW = 4;

  logic clk = 0, rst_n = 0;
  logic cs_n = 1, we_n = 1, oe_n = 1, hb_n = 1, lb_n = 1;
  logic [AW-1:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic [1:0] rdata_oe;
  logic sw_store = 0, sw_recall = 0, pwr_up = 0, pwr_fail = 0, auto_dis = 0;
  logic ext_pull = 0;
  logic busy_in, busy_out, busy_oe, ready, worn;
  logic [CW-1:0] store_cnt;

  logic [15:0] work_m [DEPTH];
  logic [15:0] shad_m [DEPTH];
  int checks = 0, fails = 0, exp_cnt = 0;

  always #10 clk = ~clk;
  assign busy_in = busy_oe ? busy_out : ~ext_pull;

  nvshadow_ctrl #(.ADDR_W(AW), .WIDE(1), .HOLD_CYC(HOLD), .ENDUR_LIMIT(LIM)) u_nvshadow_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .hb_n(hb_n), .lb_n(lb_n), .addr(addr), .wdata(wdata), .rdata(rdata),
    .rdata_oe(rdata_oe), .sw_store(sw_store), .sw_recall(sw_recall),
    .pwr_up(pwr_up), .pwr_fail(pwr_fail), .auto_dis(auto_dis),
    .busy_in(busy_in), .busy_out(busy_out), .busy_oe(busy_oe),
    .ready(ready), .store_cnt(store_cnt), .worn(worn));

  function automatic logic [15:0] merge(logic [15:0] old, logic [15:0] d, logic hb, logic lb);
    return {hb ? old[15:8] : d[15:8], lb ? old[7:0] : d[7:0]};
  endfunction

  function automatic logic [15:0] masked(logic [15:0] w, logic hb, logic lb);
    return {hb ? 8'h00 : w[15:8], lb ? 8'h00 : w[7:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic hwrite(logic [AW-1:0] a, logic [15:0] d, logic hb, logic lb);
    cs_n = 0; we_n = 0; addr = a; wdata = d; hb_n = hb; lb_n = lb;
    tick;
    cs_n = 1; we_n = 1; hb_n = 1; lb_n = 1;
    work_m[a] = merge(work_m[a], d, hb, lb);
  endtask

  task automatic hread(string req, logic [AW-1:0] a, logic hb, logic lb, logic oe);
    cs_n = 0; we_n = 1; addr = a; hb_n = hb; lb_n = lb; oe_n = oe;
    tick;
    chk(req, rdata, masked(work_m[a], hb, lb));
    chk(req, rdata_oe, oe ? 2'b00 : {~hb, ~lb});
    cs_n = 1; oe_n = 1; hb_n = 1; lb_n = 1;
  endtask

  // call one tick after the trigger edge
  task automatic run_xfer(string req, bit is_store, bit hw, bit inject);
    chk(req, ready, 0);
    chk(req, busy_oe, is_store && hw);
    for (int i = 1; i < DEPTH; i++) begin
      if (inject && i == DEPTH/2) begin
        cs_n = 0; we_n = 0; addr = 5; wdata = ~work_m[5]; hb_n = 0; lb_n = 0;
        sw_store = 1; sw_recall = 1;
      end
      tick;
      cs_n = 1; we_n = 1; hb_n = 1; lb_n = 1; sw_store = 0; sw_recall = 0;
      if (i == DEPTH/2) chk("R3 ready low mid copy", ready, 0);
    end
    tick;
    if (is_store) begin
      chk("R9 hold drive", {busy_oe, busy_out}, 2'b11);
      chk("R3 ready in hold", ready, 0);
      repeat (HOLD) tick;
      chk("R9 released", busy_oe, 0);
      for (int k = 0; k < DEPTH; k++) shad_m[k] = work_m[k];
      if (exp_cnt < LIM) exp_cnt++;
      chk("R11 count", store_cnt, exp_cnt);
    end else begin
      for (int k = 0; k < DEPTH; k++) work_m[k] = shad_m[k];
      chk("R3 busy idle after recall", busy_oe, 0);
    end
    chk(req, ready, 1);
  endtask

  initial begin : wd
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    seed = $urandom(32'd4242);
    repeat (3) tick;
    chk("reset ready", ready, 1);
    chk("reset busy", busy_oe, 0);
    chk("reset rdoe", rdata_oe, 0);
    chk("reset cnt", store_cnt, 0);
    rst_n = 1;
    tick;

    for (int a = 0; a < DEPTH; a++) hwrite(a[AW-1:0], 16'($urandom), 0, 0);

    // R1 / R2 constrained random host traffic
    for (int n = 0; n < 300; n++) begin
      logic [AW-1:0] a;
      logic hb, lb;
      a = AW'($urandom);
      hb = 1'($urandom); lb = 1'($urandom);
      if ($urandom % 2) hwrite(a, 16'($urandom), hb, lb);
      else hread("R1 R2 random", a, hb, lb, 1'($urandom % 4 == 0));
    end
    hwrite(7, 16'hABCD, 0, 1);
    hread("R1 high lane only", 7, 0, 0, 0);
    hread("R2 oe high", 7, 0, 0, 1);

    // R4 software store with injected write and commands (R3, R10)
    sw_store = 1; tick; sw_store = 0;
    run_xfer("R4 sw store", 1, 0, 1);
    tick;
    chk("R10 dropped cmd", ready, 1);
    hread("R3 write ignored", 5, 0, 0, 0);

    // R5 software recall restores shadow
    hwrite(9, 16'h1234, 0, 0);
    hwrite(10, 16'h5678, 0, 0);
    sw_recall = 1; tick; sw_recall = 0;
    run_xfer("R5 sw recall", 0, 0, 0);
    hread("R5 restored 9", 9, 0, 0, 0);
    hread("R5 restored 10", 10, 0, 0, 0);

    // R7 power-fail skip when clean, and when disabled
    pwr_fail = 1; tick;
    chk("R7 clean skip", ready, 1);
    pwr_fail = 0;
    hwrite(11, 16'h0F0F, 0, 0);
    auto_dis = 1; pwr_fail = 1; tick;
    chk("R7 disabled skip", ready, 1);
    auto_dis = 0; tick; pwr_fail = 0;
    run_xfer("R7 pf store", 1, 1, 0);

    // R8 external pull on busy line
    hwrite(12, 16'h3C3C, 0, 0);
    ext_pull = 1; tick; ext_pull = 0;
    chk("R8 line low", busy_in, 0);
    run_xfer("R8 pin store", 1, 1, 0);

    // R6 and R12: power-up beats software store
    hwrite(13, 16'hDEAD, 0, 0);
    pwr_up = 1; sw_store = 1; tick; pwr_up = 0; sw_store = 0;
    run_xfer("R6 R12 pu recall", 0, 0, 0);
    hread("R6 recalled", 13, 0, 0, 0);

    // R12: power fail beats software commands
    hwrite(14, 16'hBEEF, 0, 0);
    pwr_fail = 1; sw_recall = 1; sw_store = 1; tick;
    pwr_fail = 0; sw_recall = 0; sw_store = 0;
    run_xfer("R12 pf first", 1, 1, 0);

    // R11 endurance limit
    while (exp_cnt < LIM) begin
      sw_store = 1; tick; sw_store = 0;
      run_xfer("R11 fill", 1, 0, 0);
    end
    chk("R11 worn", worn, 1);
    sw_store = 1; tick; sw_store = 0;
    chk("R11 sw refused", ready, 1);
    ext_pull = 1; tick; ext_pull = 0; tick;
    chk("R11 pin refused", ready, 1);
    chk("R11 count held", store_cnt, LIM);
    hwrite(15, 16'h7777, 0, 0);
    hwrite(15, 16'h1111, 0, 1);
    sw_recall = 1; tick; sw_recall = 0;
    run_xfer("R5 recall when worn", 0, 0, 0);
    hread("R5 after worn", 15, 0, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule